// File: doc/BRIEF.md
# Base Address Window Decoder

This block decides which of a function's programmed base address windows an incoming transaction falls into. Software writes a base address into one of up to six slots. If the written value, with its low type-flag bits cleared, is nonzero, the slot opens a window. The window starts at that value plus a fixed platform offset. The offset chosen depends on whether the slot is of I/O type or memory type. The window is 2^k bytes long, where k is the size exponent given by the configuration side.

Each lookup presents an address and a space type. One clock later the block returns a hit flag, the index of the winning slot and the byte offset inside that window. A one-cycle change pulse tells downstream routing logic whenever a decoded window has moved. The slot type and size exponent are taken from static configuration inputs and captured at the moment a base is accepted. The configuration storage itself lives elsewhere.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every slot is closed, so every lookup misses, and the change pulse is low.
- R2: A write to slot `wr_idx` is accepted when its data, with the flag bits cleared, is nonzero. For I/O type (`cfg_is_io` bit = 1) the low 2 bits are cleared and the I/O platform base is added. For memory type (bit = 0) the low 4 bits are cleared and the memory platform base is added. The result becomes the slot's window base.
- R3: A write of all ones (size probe) changes no window and raises no change pulse.
- R4: A write whose data is zero once the flag bits are cleared changes no window and raises no change pulse.
- R5: A lookup hits a slot only when base <= address < base + 2^k. Here k is the 5-bit size exponent for that slot, taken from bits [5*i+4:5*i] of `cfg_size_log2`.
- R6: A lookup hits only slots whose captured type equals `req_is_io`.
- R7: When several windows contain the address, the slot with the lowest index wins.
- R8: On a hit, `rsp_offset` equals the address minus the winning window's base.
- R9: `win_changed` is high for exactly the one cycle after an accepted write that changes a slot's base, type or size, or that opens a closed slot. Rewriting identical values raises no pulse.
- R10: `rsp_valid` follows `req_valid` by one cycle. On a miss, `rsp_hit`, `rsp_bar` and `rsp_offset` are all zero.
- R11: The type and size exponent are captured only when a write is accepted, so later changes on the configuration inputs do not move a window. A write to an index at or above the slot count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Base write strobe |
| wr_idx | input | IDX_W (3) | Slot addressed by the write |
| wr_data | input | BAR_W (32) | Raw base value written |
| cfg_is_io | input | NUM_BARS (6) | Per-slot type, 1 = I/O, 0 = memory |
| cfg_size_log2 | input | NUM_BARS*SZ_W (30) | Per-slot size exponent, 5 bits each |
| req_valid | input | 1 | Lookup request |
| req_is_io | input | 1 | Lookup space type, 1 = I/O |
| req_addr | input | ADDR_W (40) | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Address falls inside a window |
| rsp_bar | output | IDX_W (3) | Index of the winning slot |
| rsp_offset | output | OFF_W (31) | Byte offset inside the window |
| win_changed | output | 1 | One-cycle pulse when a window moves |

## Verification
The bench probes the last byte of each window and the byte just past it, plus the byte just below the base. A decoder with an inclusive upper bound or an off-by-one lower bound would hit one of those wrongly. Overlapping windows are set up so that a reversed priority order returns a higher slot index. Size-probe writes, zero-after-mask writes and out-of-range indices are issued to catch a design that opens or moves windows on them or pulses spuriously. The bench also flips the configuration inputs after a write, which would shift or retype a window in a design that decodes them live instead of capturing them.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;

   localparam int MAX_SLOTS    = 8;
   localparam int MAX_SIZE_EXP = 6;

endpackage

// File: rtl/bar_window_slot.sv
module bar_window_slot
   import bar_dec_pkg::*;
#(
   parameter int BAR_W         = 32,
   parameter int ADDR_W        = 40,
   parameter int SZ_W          = 5,
   parameter int IO_FLAG_BITS  = 2,
   parameter int MEM_FLAG_BITS = 4,
   parameter logic [ADDR_W-1:0] IO_SPACE_BASE  = '0,
   parameter logic [ADDR_W-1:0] MEM_SPACE_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [BAR_W-1:0]  wr_data,
   input  logic              cfg_io,
   input  logic [SZ_W-1:0]   cfg_lg,
   output logic              win_en,
   output logic              win_io,
   output logic [ADDR_W-1:0] win_base,
   output logic [SZ_W-1:0]   win_lg,
   output logic              moved
);

   localparam logic [BAR_W-1:0] IO_FLAGS  = BAR_W'((64'd1 << IO_FLAG_BITS) - 64'd1);
   localparam logic [BAR_W-1:0] MEM_FLAGS = BAR_W'((64'd1 << MEM_FLAG_BITS) - 64'd1);

   logic              probe;
   logic [BAR_W-1:0]  flag_mask;
   logic [BAR_W-1:0]  masked;
   logic [ADDR_W-1:0] new_base;
   logic              accept;

   always_comb begin
      probe     = &wr_data;
      flag_mask = (space_e'(cfg_io) == SPACE_IO) ? IO_FLAGS : MEM_FLAGS;
      masked    = wr_data & ~flag_mask;
      new_base  = ADDR_W'(masked) +
                  ((space_e'(cfg_io) == SPACE_IO) ? IO_SPACE_BASE : MEM_SPACE_BASE);
      accept    = wr_sel && !probe && (masked != '0);
      moved     = accept && (!win_en || (new_base != win_base) ||
                             (cfg_io != win_io) || (cfg_lg != win_lg));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_en   <= 1'b0;
         win_io   <= 1'b0;
         win_base <= '0;
         win_lg   <= '0;
      end else if (accept) begin
         win_en   <= 1'b1;
         win_io   <= cfg_io;
         win_base <= new_base;
         win_lg   <= cfg_lg;
      end
   end

endmodule

// File: rtl/bar_window_match.sv
module bar_window_match #(
   parameter int ADDR_W = 40,
   parameter int SZ_W   = 5,
   parameter int OFF_W  = 31
) (
   input  logic              win_en,
   input  logic              win_io,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [SZ_W-1:0]   win_lg,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              in_win,
   output logic [OFF_W-1:0]  offset
);

   logic [ADDR_W:0]   diff;
   logic [ADDR_W-1:0] above;
   logic [OFF_W-1:0]  lim;

   always_comb begin
      diff   = {1'b0, req_addr} - {1'b0, win_base};
      above  = diff[ADDR_W-1:0] >> win_lg;
      lim    = (OFF_W'(1) << win_lg) - OFF_W'(1);
      in_win = win_en && (win_io == req_io) && !diff[ADDR_W] && (above == '0);
      offset = diff[OFF_W-1:0] & lim;
   end

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select #(
   parameter int NUM_BARS = 6,
   parameter int IDX_W    = 3,
   parameter int OFF_W    = 31,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [NUM_BARS-1:0]       in_win,
   input  logic [NUM_BARS*OFF_W-1:0] off_flat,
   output logic                      rsp_valid,
   output logic                      rsp_hit,
   output logic [IDX_W-1:0]          rsp_bar,
   output logic [OFF_W-1:0]          rsp_offset
);

   logic             sel_hit;
   logic [IDX_W-1:0] sel_idx;
   logic [OFF_W-1:0] sel_off;

   // Walk from the top index down so the lowest matching slot is the last one kept.
   always_comb begin
      sel_hit = 1'b0;
      sel_idx = '0;
      sel_off = '0;
      for (int i = NUM_BARS - 1; i >= 0; i--) begin
         if (req_valid && in_win[i]) begin
            sel_hit = 1'b1;
            sel_idx = IDX_W'(i);
            sel_off = off_flat[i*OFF_W +: OFF_W];
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rsp_valid  <= 1'b0;
               rsp_hit    <= 1'b0;
               rsp_bar    <= '0;
               rsp_offset <= '0;
            end else begin
               rsp_valid  <= req_valid;
               rsp_hit    <= sel_hit;
               rsp_bar    <= sel_idx;
               rsp_offset <= sel_off;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rsp_valid  = req_valid;
         assign rsp_hit    = sel_hit;
         assign rsp_bar    = sel_idx;
         assign rsp_offset = sel_off;
      end
   endgenerate

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_dec_pkg::*;
#(
   parameter int NUM_BARS      = 6,
   parameter int BAR_W         = 32,
   parameter int ADDR_W        = 40,
   parameter int SZ_W          = 5,
   parameter int IO_FLAG_BITS  = 2,
   parameter int MEM_FLAG_BITS = 4,
   parameter logic [ADDR_W-1:0] IO_SPACE_BASE  = ADDR_W'(64'h80_0000_0000),
   parameter logic [ADDR_W-1:0] MEM_SPACE_BASE = ADDR_W'(64'h10_0000_0000),
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1,
   localparam int OFF_W = (1 << SZ_W) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [BAR_W-1:0]         wr_data,
   input  logic [NUM_BARS-1:0]      cfg_is_io,
   input  logic [NUM_BARS*SZ_W-1:0] cfg_size_log2,
   input  logic                     req_valid,
   input  logic                     req_is_io,
   input  logic [ADDR_W-1:0]        req_addr,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic [IDX_W-1:0]         rsp_bar,
   output logic [OFF_W-1:0]         rsp_offset,
   output logic                     win_changed
);

   if (NUM_BARS < 1 || NUM_BARS > MAX_SLOTS) begin : g_chk_bars
      $error("bar_window_decoder: NUM_BARS out of range");
   end
   if (SZ_W < 1 || SZ_W > MAX_SIZE_EXP) begin : g_chk_sz
      $error("bar_window_decoder: SZ_W out of range");
   end
   if (ADDR_W <= BAR_W || OFF_W > ADDR_W) begin : g_chk_addr
      $error("bar_window_decoder: ADDR_W too narrow");
   end
   if (IO_FLAG_BITS < 0 || MEM_FLAG_BITS < 0 ||
       IO_FLAG_BITS >= BAR_W || MEM_FLAG_BITS >= BAR_W) begin : g_chk_flags
      $error("bar_window_decoder: flag widths out of range");
   end

   logic [NUM_BARS-1:0]       w_en;
   logic [NUM_BARS-1:0]       w_io;
   logic [NUM_BARS-1:0]       w_moved;
   logic [NUM_BARS-1:0]       w_in;
   logic [NUM_BARS*OFF_W-1:0] w_off;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
      logic [ADDR_W-1:0] base_i;
      logic [SZ_W-1:0]   lg_i;
      logic              sel_i;

      assign sel_i = wr_en && (wr_idx == IDX_W'(i));

      bar_window_slot #(
         .BAR_W          (BAR_W),
         .ADDR_W         (ADDR_W),
         .SZ_W           (SZ_W),
         .IO_FLAG_BITS   (IO_FLAG_BITS),
         .MEM_FLAG_BITS  (MEM_FLAG_BITS),
         .IO_SPACE_BASE  (IO_SPACE_BASE),
         .MEM_SPACE_BASE (MEM_SPACE_BASE)
      ) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sel   (sel_i),
         .wr_data  (wr_data),
         .cfg_io   (cfg_is_io[i]),
         .cfg_lg   (cfg_size_log2[i*SZ_W +: SZ_W]),
         .win_en   (w_en[i]),
         .win_io   (w_io[i]),
         .win_base (base_i),
         .win_lg   (lg_i),
         .moved    (w_moved[i])
      );

      bar_window_match #(
         .ADDR_W (ADDR_W),
         .SZ_W   (SZ_W),
         .OFF_W  (OFF_W)
      ) match_i (
         .win_en   (w_en[i]),
         .win_io   (w_io[i]),
         .win_base (base_i),
         .win_lg   (lg_i),
         .req_io   (req_is_io),
         .req_addr (req_addr),
         .in_win   (w_in[i]),
         .offset   (w_off[i*OFF_W +: OFF_W])
      );
   end

   bar_hit_select #(
      .NUM_BARS (NUM_BARS),
      .IDX_W    (IDX_W),
      .OFF_W    (OFF_W),
      .OUT_REG  (OUT_REG)
   ) sel_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .in_win     (w_in),
      .off_flat   (w_off),
      .rsp_valid  (rsp_valid),
      .rsp_hit    (rsp_hit),
      .rsp_bar    (rsp_bar),
      .rsp_offset (rsp_offset)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) win_changed <= 1'b0;
      else        win_changed <= |w_moved;
   end

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
   parameter int NUM_BARS = 6,
   parameter int IDX_W    = 3,
   parameter int OFF_W    = 31,
   parameter int BAR_W    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [BAR_W-1:0] wr_data,
   input logic             req_valid,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [IDX_W-1:0] rsp_bar,
   input logic [OFF_W-1:0] rsp_offset,
   input logic             win_changed
);

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_hit_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_bar == '0 && rsp_offset == '0));

   assert_bar_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (int'(rsp_bar) < NUM_BARS));

   assert_pulse_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_changed |-> $past(wr_en));

   assert_probe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (&wr_data)) |=> !win_changed);

   assert_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == '0) |=> !win_changed);

   assert_bad_idx_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) >= NUM_BARS) |=> !win_changed);

endmodule

bind bar_window_decoder bar_window_decoder_chk #(
   .NUM_BARS (NUM_BARS),
   .IDX_W    (IDX_W),
   .OFF_W    (OFF_W),
   .BAR_W    (BAR_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_data     (wr_data),
   .req_valid   (req_valid),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_bar     (rsp_bar),
   .rsp_offset  (rsp_offset),
   .win_changed (win_changed)
);

// File: tb/bar_window_decoder_tb.sv
`timescale 1ns/1ps
module bar_window_decoder_tb_top;

   localparam int NB = 6;
   localparam int SZ = 5;
   localparam longint unsigned IOB  = 64'h80_0000_0000;
   localparam longint unsigned MEMB = 64'h10_0000_0000;
   localparam longint unsigned AMASK = 64'hFF_FFFF_FFFF;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_idx = '0;
   logic [31:0]    wr_data = '0;
   logic [NB-1:0]  cfg_is_io = '0;
   logic [NB*SZ-1:0] cfg_size_log2 = '0;
   logic           req_valid = 1'b0;
   logic           req_is_io = 1'b0;
   logic [39:0]    req_addr = '0;
   logic           rsp_valid, rsp_hit, win_changed;
   logic [2:0]     rsp_bar;
   logic [30:0]    rsp_offset;

   int n_checks = 0;
   int n_fails  = 0;

   // bench model of the windows
   bit              m_en [NB];
   bit              m_io [NB];
   longint unsigned m_base [NB];
   int              m_lg [NB];

   always #2 clk = ~clk;

   bar_window_decoder #(
      .IO_SPACE_BASE  (40'h80_0000_0000),
      .MEM_SPACE_BASE (40'h10_0000_0000)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .cfg_is_io(cfg_is_io), .cfg_size_log2(cfg_size_log2),
      .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bar(rsp_bar),
      .rsp_offset(rsp_offset), .win_changed(win_changed));

   task automatic check(input bit ok, input string req, input longint unsigned act,
                        input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit model_write(input int idx, input bit io, input int lg,
                                      input logic [31:0] data);
      longint unsigned masked, nb;
      bit mv;
      if (idx >= NB || data == 32'hFFFF_FFFF) return 1'b0;
      masked = longint'(data) & (io ? ~64'h3 : ~64'hF);
      if (masked == 0) return 1'b0;
      nb = masked + (io ? IOB : MEMB);
      mv = !m_en[idx] || nb != m_base[idx] || io != m_io[idx] || lg != m_lg[idx];
      m_en[idx] = 1'b1; m_io[idx] = io; m_base[idx] = nb; m_lg[idx] = lg;
      return mv;
   endfunction

   task automatic do_write(input int idx, input bit io, input int lg,
                           input logic [31:0] data, input string req);
      bit exp_mv;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_data = data;
      if (idx < NB) begin
         cfg_is_io[idx] = io;
         cfg_size_log2[idx*SZ +: SZ] = SZ'(lg);
      end
      exp_mv = model_write(idx, io, lg, data);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check(win_changed == exp_mv, req, longint'(win_changed), longint'(exp_mv));
      @(posedge clk);
      @(negedge clk);
      check(win_changed == 1'b0, "R9", longint'(win_changed), 0);
   endtask

   task automatic do_lookup(input bit io, input longint unsigned addr, input string req);
      bit e_hit; int e_bar; longint unsigned e_off;
      e_hit = 0; e_bar = 0; e_off = 0;
      addr = addr & AMASK;
      for (int i = 0; i < NB; i++) begin
         if (!e_hit && m_en[i] && m_io[i] == io && addr >= m_base[i] &&
             addr < m_base[i] + (64'd1 << m_lg[i])) begin
            e_hit = 1; e_bar = i; e_off = addr - m_base[i];
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_is_io = io; req_addr = addr[39:0];
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R10", longint'(rsp_valid), 1);
      check(rsp_hit == e_hit, req, longint'(rsp_hit), longint'(e_hit));
      check(int'(rsp_bar) == e_bar, req, longint'(rsp_bar), longint'(e_bar));
      check(longint'(rsp_offset) == e_off, req, longint'(rsp_offset), e_off);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < NB; i++) begin
         m_en[i] = 0; m_io[i] = 0; m_base[i] = 0; m_lg[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(win_changed == 1'b0 && rsp_valid == 1'b0, "R1", longint'(win_changed), 0);
      rst_n = 1'b1;
      do_lookup(1'b0, MEMB + 64'h1000, "R1");
      do_lookup(1'b1, IOB, "R1");

      // R2: memory slot 0, flag bits dropped
      do_write(0, 1'b0, 12, 32'h0000_100F, "R2");
      do_lookup(1'b0, MEMB + 64'h1000, "R2");
      do_lookup(1'b0, MEMB + 64'h1FFF, "R5");
      do_lookup(1'b0, MEMB + 64'h2000, "R5");
      do_lookup(1'b0, MEMB + 64'h0FFF, "R5");
      do_lookup(1'b0, MEMB + 64'h1234, "R8");
      do_lookup(1'b1, MEMB + 64'h1000, "R6");
      // R2: I/O slot 2
      do_write(2, 1'b1, 8, 32'h0000_2003, "R2");
      do_lookup(1'b1, IOB + 64'h2010, "R2");
      do_lookup(1'b0, IOB + 64'h2010, "R6");
      do_lookup(1'b1, IOB + 64'h20FF, "R5");
      do_lookup(1'b1, IOB + 64'h2100, "R5");
      // R3: size probe
      do_write(0, 1'b0, 12, 32'hFFFF_FFFF, "R3");
      do_lookup(1'b0, MEMB + 64'h1000, "R3");
      // R4: zero after masking
      do_write(1, 1'b0, 12, 32'h0000_000C, "R4");
      do_write(1, 1'b1, 12, 32'h0000_0000, "R4");
      do_lookup(1'b0, MEMB + 64'h0, "R4");
      // R9: identical rewrite
      do_write(0, 1'b0, 12, 32'h0000_1000, "R9");
      // R7: overlaps
      do_write(3, 1'b0, 16, 32'h0000_1000, "R7");
      do_write(1, 1'b0, 4, 32'h0000_1000, "R7");
      do_lookup(1'b0, MEMB + 64'h1008, "R7");
      do_lookup(1'b0, MEMB + 64'h1800, "R7");
      do_lookup(1'b0, MEMB + 64'h8000, "R7");
      // R11: out-of-range index and live config changes
      do_write(7, 1'b0, 12, 32'h0000_5000, "R11");
      do_write(6, 1'b1, 12, 32'h0000_5000, "R11");
      @(negedge clk);
      cfg_is_io = ~cfg_is_io;
      cfg_size_log2 = '0;
      do_lookup(1'b0, MEMB + 64'h1FF0, "R11");
      do_lookup(1'b1, IOB + 64'h2080, "R11");
      // R9: move a window
      do_write(0, 1'b0, 12, 32'h0000_3000, "R9");
      do_lookup(1'b0, MEMB + 64'h3000, "R9");
      do_lookup(1'b0, MEMB + 64'h1800, "R9");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         if (($urandom % 3) == 0) begin
            int idx, lg; bit io; logic [31:0] d; int pick;
            idx = int'($urandom % 8);
            io  = 1'($urandom % 2);
            lg  = 2 + int'($urandom % 19);
            pick = int'($urandom % 10);
            if (pick == 0)      d = 32'hFFFF_FFFF;
            else if (pick == 1) d = 32'($urandom % 16);
            else                d = $urandom & 32'h00FF_FFFF;
            do_write(idx, io, lg, d, "R9");
         end else begin
            int b; bit io; longint unsigned a;
            b = int'($urandom % NB);
            if (m_en[b]) begin
               a = m_base[b] + longint'($urandom % ((32'd1 << m_lg[b]) + 16)) - 8;
               io = (($urandom % 4) == 0) ? !m_io[b] : m_io[b];
            end else begin
               io = 1'($urandom % 2);
               a = (io ? IOB : MEMB) + longint'($urandom & 32'h00FF_FFFF);
            end
            do_lookup(io, a, "R5");
         end
      end

      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule